// File: doc/BRIEF.md
# Picture-Bus Tile Bank and Mirroring Mapper

This block sits on the picture-processor side of a cartridge mapper. It holds eight 8-bit bank numbers, one for each 1 KB slice of the 8 KB pattern space, and a 2-bit nametable arrangement mode. All nine values are loaded through a shared indirect command write. A 4-bit command selector names the target and an 8-bit data byte carries the value. The write takes effect at the clock edge on which the strobe is high.

On the address side the block is purely combinational. The picture-processor address (14 bits) is turned into an 18-bit pattern-ROM address, so up to 256 KB of pattern memory can be reached. Address bit 13 steers each access either to the pattern ROM or to the console's internal video RAM. For the video RAM the block drives the page-select line that picks one of its two 1 KB nametable pages, following the chosen arrangement mode.

Selector values 8 to 11 and 13 to 15 belong to other parts of the mapper. This block ignores them.

Top module: `tile_bank_mapper`

## Requirements
- R1: While `rst` is high at a clock edge, all eight bank numbers become 0 and the arrangement mode becomes 0 (vertical).
- R2: A clock edge with `cmd_wr` high and `cmd_sel` = n, for n in 0..7, loads `cmd_data[7:0]` into bank n. The outputs show the new value from that edge on.
- R3: `pat_addr` = {bank[k], `ppu_addr[9:0]`}, where k = `ppu_addr[12:10]`. Window k therefore spans picture addresses k*0x400 to k*0x400+0x3FF.
- R4: `pat_ce` is high exactly when `ppu_addr[13]` is 0, and `vram_ce` is high exactly when `ppu_addr[13]` is 1.
- R5: A clock edge with `cmd_wr` high and `cmd_sel` = 12 loads `cmd_data[1:0]` as the arrangement mode. Bits 7:2 have no effect.
- R6: In mode 0 (vertical), `vram_a10` equals `ppu_addr[10]`.
- R7: In mode 1 (horizontal), `vram_a10` equals `ppu_addr[11]`.
- R8: In mode 2, `vram_a10` is constantly 0 (lower page only). In mode 3 it is constantly 1 (upper page only).
- R9: A write with `cmd_sel` in 8..11 or 13..15 changes neither the banks nor the mode. Data presented while `cmd_wr` is low also changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_sel | input | 4 | Command selector (0-7 banks, 12 mode) |
| cmd_data | input | 8 | Command parameter byte |
| ppu_addr | input | 14 | Picture-processor address |
| pat_addr | output | 18 | Pattern-ROM address |
| pat_ce | output | 1 | Pattern-ROM enable |
| vram_ce | output | 1 | Internal video-RAM enable |
| vram_a10 | output | 1 | Nametable page select for internal video RAM |

## Verification
Each bank register is first given a distinct value. The picture address is then swept across every window edge (0x03FF/0x0400 and the like, plus 0x1FFF/0x2000). A swapped or misdecoded window index would therefore show up as a wrong high address part.

The four arrangement modes are each tried with the data byte's upper bits set. The sweep covers nametable addresses that differ only in bit 10, only in bit 11, or in both, which separates vertical from horizontal and both of them from the two fixed single-page modes.

Ignored selectors and strobe-less data use all-ones bytes, so any leak into a register changes the observed address.

// File: rtl/tile_map_pkg.sv
package tile_map_pkg;

    parameter int CMD_W  = 4;
    parameter int DATA_W = 8;
    parameter int PPU_AW = 14;

    localparam logic [CMD_W-1:0] CMD_ARRANGE = CMD_W'(12);

    typedef enum logic [1:0] {
        MIR_VERT     = 2'd0,
        MIR_HORZ     = 2'd1,
        MIR_ONE_LOW  = 2'd2,
        MIR_ONE_HIGH = 2'd3
    } mirror_e;

    typedef struct packed {
        logic              wr;
        logic [CMD_W-1:0]  sel;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic page_bit(mirror_e m, logic a10, logic a11);
        case (m)
            MIR_VERT:    return a10;
            MIR_HORZ:    return a11;
            MIR_ONE_LOW: return 1'b0;
            default:     return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tile_bank_regs.sv
module tile_bank_regs
    import tile_map_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int BANK_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  cmd_t                            cmd,
    output logic [NUM_WIN-1:0][BANK_W-1:0]  bank_q,
    output mirror_e                         mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            mode_q <= MIR_VERT;
        end else if (cmd.wr) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (cmd.sel == CMD_W'(i))
                    bank_q[i] <= cmd.data[BANK_W-1:0];
            end
            if (cmd.sel == CMD_ARRANGE)
                mode_q <= mirror_e'(cmd.data[1:0]);
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_load_chk
        AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
            (cmd.wr && cmd.sel == CMD_W'(g)) |=> (bank_q[g] == $past(cmd.data[BANK_W-1:0])))
            else $error("bank load mismatch"); // R2
    end

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == CMD_ARRANGE) |=> (mode_q == mirror_e'($past(cmd.data[1:0]))))
        else $error("mode load mismatch"); // R5

    AST_IGNORED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd.wr || (cmd.sel >= CMD_W'(NUM_WIN) && cmd.sel != CMD_ARRANGE))
        |=> ($stable(bank_q) && $stable(mode_q)))
        else $error("state changed on ignored command"); // R9

endmodule

// File: rtl/tile_addr_mux.sv
module tile_addr_mux
    import tile_map_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int BANK_W   = 8,
    parameter int WIN_BITS = 10
) (
    input  logic [NUM_WIN-1:0][BANK_W-1:0] bank_q,
    input  logic [PPU_AW-1:0]              ppu_addr,
    output logic [BANK_W+WIN_BITS-1:0]     pat_addr,
    output logic                           pat_ce
);

    localparam int SEL_W = $clog2(NUM_WIN);

    logic [SEL_W-1:0] win;

    always_comb begin
        win      = ppu_addr[WIN_BITS +: SEL_W];
        pat_addr = {bank_q[win], ppu_addr[WIN_BITS-1:0]};
        pat_ce   = ~ppu_addr[PPU_AW-1];
    end

endmodule

// File: rtl/tile_page_sel.sv
module tile_page_sel
    import tile_map_pkg::*;
(
    input  mirror_e mode_q,
    input  logic    a13,
    input  logic    a11,
    input  logic    a10,
    output logic    vram_ce,
    output logic    vram_a10
);

    always_comb begin
        vram_ce  = a13;
        vram_a10 = page_bit(mode_q, a10, a11);
    end

endmodule

// File: rtl/tile_bank_mapper.sv
module tile_bank_mapper
    import tile_map_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int BANK_W   = 8,
    parameter int WIN_BITS = 10,
    localparam int PAT_AW  = BANK_W + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_sel,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [PAT_AW-1:0] pat_addr,
    output logic              pat_ce,
    output logic              vram_ce,
    output logic              vram_a10
);

    cmd_t                           cmd;
    logic [NUM_WIN-1:0][BANK_W-1:0] bank_q;
    mirror_e                        mode_q;

    assign cmd = '{wr: cmd_wr, sel: cmd_sel, data: cmd_data};

    tile_bank_regs #(.NUM_WIN(NUM_WIN), .BANK_W(BANK_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .bank_q (bank_q),
        .mode_q (mode_q)
    );

    tile_addr_mux #(.NUM_WIN(NUM_WIN), .BANK_W(BANK_W), .WIN_BITS(WIN_BITS)) u_mux (
        .bank_q   (bank_q),
        .ppu_addr (ppu_addr),
        .pat_addr (pat_addr),
        .pat_ce   (pat_ce)
    );

    tile_page_sel u_page (
        .mode_q   (mode_q),
        .a13      (ppu_addr[PPU_AW-1]),
        .a11      (ppu_addr[WIN_BITS+1]),
        .a10      (ppu_addr[WIN_BITS]),
        .vram_ce  (vram_ce),
        .vram_a10 (vram_a10)
    );

    AST_CE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot({pat_ce, vram_ce}))
        else $error("enables not exclusive"); // R4

    AST_VERT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MIR_VERT) |-> (vram_a10 == ppu_addr[WIN_BITS]))
        else $error("vertical page wrong"); // R6

    AST_HORZ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MIR_HORZ) |-> (vram_a10 == ppu_addr[WIN_BITS+1]))
        else $error("horizontal page wrong"); // R7

    AST_SINGLE_PAGE: assert property (@(posedge clk) disable iff (rst)
        (mode_q[1]) |-> (vram_a10 == mode_q[0]))
        else $error("single page wrong"); // R8

endmodule

// File: tb/tile_bank_mapper_test.sv
`timescale 1ns/1ps
module tile_bank_mapper_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [3:0]  cmd_sel = '0;
    logic [7:0]  cmd_data = '0;
    logic [13:0] ppu_addr = '0;
    logic [17:0] pat_addr;
    logic        pat_ce, vram_ce, vram_a10;

    int n_checks = 0;
    int n_fail   = 0;
    bit checking = 1'b0;
    string tag   = "R1";

    int ref_bank [8];
    int ref_mode;

    always #2.5 clk = ~clk;

    tile_bank_mapper uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
        .cmd_data(cmd_data), .ppu_addr(ppu_addr), .pat_addr(pat_addr),
        .pat_ce(pat_ce), .vram_ce(vram_ce), .vram_a10(vram_a10)
    );

    // behavioural reference: plain integers updated at each edge
    always @(posedge clk) begin
        if (rst) begin
            foreach (ref_bank[i]) ref_bank[i] = 0;
            ref_mode = 0;
        end else if (cmd_wr) begin
            if (cmd_sel < 8) ref_bank[cmd_sel] = cmd_data;
            else if (cmd_sel == 12) ref_mode = cmd_data % 4;
        end
        checking = 1'b1;
    end

    task automatic cmp(string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            int a, win, exp_pa, exp_pg;
            #1;
            a      = ppu_addr;
            win    = (a / 1024) % 8;
            exp_pa = ref_bank[win] * 1024 + (a % 1024);
            case (ref_mode)
                0: exp_pg = (a / 1024) % 2;
                1: exp_pg = (a / 2048) % 2;
                2: exp_pg = 0;
                default: exp_pg = 1;
            endcase
            cmp("pat_addr", pat_addr, exp_pa);
            cmp("pat_ce", pat_ce, (a < 8192) ? 1 : 0);
            cmp("vram_ce", vram_ce, (a >= 8192) ? 1 : 0);
            cmp("vram_a10", vram_a10, exp_pg);
        end
    end

    task automatic put(int sel, int data, bit wr);
        @(negedge clk);
        cmd_wr   = wr;
        cmd_sel  = 4'(sel);
        cmd_data = 8'(data);
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic sweep_windows();
        for (int w = 0; w < 8; w++) begin
            @(negedge clk) ppu_addr = 14'(w * 1024);
            @(negedge clk) ppu_addr = 14'(w * 1024 + 1023);
            @(negedge clk) ppu_addr = 14'(w * 1024 + 337);
        end
        @(negedge clk) ppu_addr = 14'h2000;
    endtask

    task automatic sweep_tables();
        int pts [6] = '{'h2000, 'h2400, 'h2800, 'h2C00, 'h3EFF, 'h1400};
        foreach (pts[i]) begin
            @(negedge clk) ppu_addr = 14'(pts[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        sweep_windows();
        sweep_tables();
        @(negedge clk) rst = 1'b0;

        tag = "R2";
        for (int b = 0; b < 8; b++) put(b, (b * 37 + 165) % 256, 1'b1);
        tag = "R3";
        sweep_windows();
        tag = "R4";
        sweep_tables();

        tag = "R9";
        for (int s = 8; s < 16; s++) if (s != 12) put(s, 255, 1'b1);
        for (int s = 0; s < 16; s++) put(s, 255, 1'b0);
        sweep_windows();
        sweep_tables();

        tag = "R7";
        put(12, 'hFD, 1'b1);
        sweep_tables();
        tag = "R8";
        put(12, 'hFE, 1'b1);
        sweep_tables();
        put(12, 'h07, 1'b1);
        sweep_tables();
        tag = "R6";
        put(12, 'hFC, 1'b1);
        sweep_tables();
        tag = "R5";
        put(12, 'h81, 1'b1);
        sweep_tables();

        tag = "R2";
        put(3, 0, 1'b1);
        put(7, 255, 1'b1);
        sweep_windows();

        tag = "R1";
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        sweep_windows();
        sweep_tables();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog timeout got running exp finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule